// File: doc/BRIEF.md
# USB High-Speed Chirp Handshake Sequencer

This block is the device-side controller that negotiates high-speed operation after a bus reset on a USB 2.0 link whose transceiver is reached through a ULPI-style link interface. While idle it watches the two-bit line state from the PHY. Once it sees a single-ended zero held long enough, it takes the transceiver into chirp mode with a register write. It then sends a no-PID transmit command and drives a Chirp K for a fixed number of clock cycles. After that it listens for the host's alternating K and J chirps.

If the host answers with enough K-J pairs before a timeout, the block writes the high-speed setting and raises `hs_mode`. If the host does not answer in time, it restores the full-speed setting and goes back to watching for a reset. Register writes go to an external register access engine through a request/acknowledge pair. Transmit bytes go to the transmit path, which paces the command byte with `tx_nxt`. All windows are counted in link clock cycles (60 MHz in the target), and parameters set their lengths.

Top module: `hs_chirp_seq`

## Requirements
- R1: In the idle state, when `line_state` reads 2'b00 (SE0) on SE0_CYC consecutive clock edges, a register write request follows to address 6'h04 with data 8'h14. The data fields are: transceiver select in bits 1:0 = 00, termination in bit 2 = 1, operating mode in bits 4:3 = 10. A shorter SE0 run causes no request.
- R2: `reg_req` stays high with `reg_addr` and `reg_data` unchanged until a cycle in which `reg_ack` is high, and it is low in the following cycle.
- R3: After the chirp-mode write is acknowledged, `tx_valid` is high and `tx_data` holds 8'h40 until a cycle in which `tx_nxt` is high.
- R4: After the command is accepted, `tx_data` is 8'h00 with `tx_valid` high for exactly CHIRP_CYC cycles. Then `tx_stp` is high for exactly one cycle.
- R5: While listening, a pair is counted only when `diff_valid` is high for both halves. A pair is a K (line state 2'b10) followed later by a J (2'b01). Repeated K samples count once. A J with no K before it is ignored.
- R6: When PAIRS pairs have been counted, a register write of 8'h00 to address 6'h04 follows. This selects high-speed transceiver, termination 0 and normal mode. `hs_mode` rises in the cycle after its acknowledge and then stays high.
- R7: If PAIRS pairs are not counted within HOST_TO cycles of entering the listen phase, `reg_req` rises exactly HOST_TO cycles after that entry. The request writes 8'h05 to address 6'h04 (full-speed transceiver 01, termination 1, normal mode). After its acknowledge the block is idle with `hs_mode` low, and a new SE0 restarts the sequence.
- R8: After reset, `reg_req`, `tx_valid`, `tx_stp` and `hs_mode` are low.
- R9: `reg_req` and `tx_valid` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_state | input | 2 | PHY line state: 00 SE0, 01 J, 10 K |
| diff_valid | input | 1 | High-speed differential receiver reports a valid symbol |
| reg_req | output | 1 | Register write request to the access engine |
| reg_addr | output | 6 | Register address of the request |
| reg_data | output | 8 | Register write data |
| reg_ack | input | 1 | Access engine has completed the write |
| tx_valid | output | 1 | Transmit path is being driven |
| tx_data | output | 8 | Transmit command or chirp data byte |
| tx_nxt | input | 1 | Transmit path accepted the command byte |
| tx_stp | output | 1 | Ends the transmission |
| hs_mode | output | 1 | High-speed mode negotiated |

## Verification
The assertions assume that the register engine raises `reg_ack` only while a request is pending. They also assume that `tx_nxt` matters only while the command byte is presented, and that the line state is a settled two-bit code at each clock edge. The stimulus respects all three. The bench pulses `reg_ack` for one cycle only after it has seen `reg_req` high, raises `tx_nxt` only while it sees 8'h40, and changes `line_state` and `diff_valid` only on falling clock edges.

// File: rtl/chirp_pkg.sv
package chirp_pkg;

    typedef enum logic [1:0] {
        LS_SE0 = 2'b00,
        LS_J   = 2'b01,
        LS_K   = 2'b10,
        LS_SE1 = 2'b11
    } line_t;

    typedef enum logic [3:0] {
        S_IDLE,
        S_WR_CHIRP,
        S_TX_CMD,
        S_TX_CHIRP,
        S_TX_STP,
        S_LISTEN,
        S_WR_HS,
        S_WR_FS,
        S_HS
    } seq_t;

    typedef struct packed {
        seq_t st;
        logic hs;
    } ctl_t;

    localparam logic [5:0] FCTRL_ADDR  = 6'h04;
    localparam logic [7:0] TXCMD_NOPID = 8'h40;

    // Field layout decoded by the transceiver: op[4:3], term[2], xcvr[1:0]
    function automatic logic [7:0] fctrl(input logic [1:0] xcvr, input logic term,
                                         input logic [1:0] op);
        return {3'b000, op, term, xcvr};
    endfunction

    localparam logic [7:0] FC_CHIRP = 8'h14;
    localparam logic [7:0] FC_HS    = 8'h00;
    localparam logic [7:0] FC_FS    = 8'h05;

endpackage

// File: rtl/se0_watch.sv
module se0_watch
    import chirp_pkg::*;
#(
    parameter int SE0_CYC = 150
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic [1:0] line_state,
    output logic       se0_seen
);
    localparam int W = $clog2(SE0_CYC + 1);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!en || line_state != LS_SE0) begin
            cnt_d = '0;
        end else if (cnt_q != W'(SE0_CYC)) begin
            cnt_d = cnt_q + W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign se0_seen = (cnt_q == W'(SE0_CYC));

    // R1: a full SE0 window was really on the line at the previous edge
    p_seen_follows_se0_r1: assert property (@(posedge clk) disable iff (!rst_n)
        se0_seen |-> $past(line_state) == LS_SE0);

endmodule

// File: rtl/kj_pairs.sv
module kj_pairs
    import chirp_pkg::*;
#(
    parameter int PAIRS = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       diff_valid,
    input  logic [1:0] line_state,
    output logic       done
);
    localparam int W = $clog2(PAIRS + 1);

    logic [W-1:0] cnt_d, cnt_q;
    logic         k_d, k_q;

    always_comb begin
        cnt_d = cnt_q;
        k_d   = k_q;
        if (clr) begin
            cnt_d = '0;
            k_d   = 1'b0;
        end else if (diff_valid) begin
            if (line_state == LS_K) begin
                k_d = 1'b1;
            end else if (line_state == LS_J && k_q) begin
                k_d = 1'b0;
                if (cnt_q != W'(PAIRS)) cnt_d = cnt_q + W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            k_q   <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            k_q   <= k_d;
        end
    end

    assign done = (cnt_q == W'(PAIRS));

    // R5: pairs advance by at most one per cycle while counting
    p_pair_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + W'(1)));

endmodule

// File: rtl/phase_timer.sv
module phase_timer #(
    parameter int W = 17
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    output logic [W-1:0] cnt
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (clr)                  cnt_d = '0;
        else if (cnt_q == '1)     cnt_d = cnt_q;
        else                      cnt_d = cnt_q + W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;

endmodule

// File: rtl/hs_chirp_seq.sv
module hs_chirp_seq
    import chirp_pkg::*;
#(
    parameter int SE0_CYC   = 150,
    parameter int CHIRP_CYC = 66000,
    parameter int HOST_TO   = 360000,
    parameter int PAIRS     = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] line_state,
    input  logic       diff_valid,
    output logic       reg_req,
    output logic [5:0] reg_addr,
    output logic [7:0] reg_data,
    input  logic       reg_ack,
    output logic       tx_valid,
    output logic [7:0] tx_data,
    input  logic       tx_nxt,
    output logic       tx_stp,
    output logic       hs_mode
);
    localparam int TMAX = (CHIRP_CYC > HOST_TO) ? CHIRP_CYC : HOST_TO;
    localparam int TW   = $clog2(TMAX + 1);

    ctl_t          d, q;
    logic          se0_en, se0_seen;
    logic          kj_clr, kj_done;
    logic          tmr_clr;
    logic [TW-1:0] tmr;

    se0_watch #(.SE0_CYC(SE0_CYC)) u_se0 (
        .clk(clk), .rst_n(rst_n), .en(se0_en),
        .line_state(line_state), .se0_seen(se0_seen)
    );

    kj_pairs #(.PAIRS(PAIRS)) u_kj (
        .clk(clk), .rst_n(rst_n), .clr(kj_clr), .diff_valid(diff_valid),
        .line_state(line_state), .done(kj_done)
    );

    phase_timer #(.W(TW)) u_tmr (
        .clk(clk), .rst_n(rst_n), .clr(tmr_clr), .cnt(tmr)
    );

    always_comb begin
        d        = q;
        se0_en   = 1'b0;
        kj_clr   = 1'b1;
        tmr_clr  = 1'b0;
        reg_req  = 1'b0;
        reg_addr = FCTRL_ADDR;
        reg_data = 8'h00;
        tx_valid = 1'b0;
        tx_data  = 8'h00;
        tx_stp   = 1'b0;
        unique case (q.st)
            S_IDLE: begin
                se0_en = 1'b1;
                if (se0_seen) d.st = S_WR_CHIRP;
            end
            S_WR_CHIRP: begin
                reg_req  = 1'b1;
                reg_data = fctrl(2'b00, 1'b1, 2'b10);
                if (reg_ack) d.st = S_TX_CMD;
            end
            S_TX_CMD: begin
                tx_valid = 1'b1;
                tx_data  = TXCMD_NOPID;
                tmr_clr  = 1'b1;
                if (tx_nxt) d.st = S_TX_CHIRP;
            end
            S_TX_CHIRP: begin
                tx_valid = 1'b1;
                if (tmr == TW'(CHIRP_CYC - 1)) d.st = S_TX_STP;
            end
            S_TX_STP: begin
                tx_valid = 1'b1;
                tx_stp   = 1'b1;
                tmr_clr  = 1'b1;
                d.st     = S_LISTEN;
            end
            S_LISTEN: begin
                kj_clr = 1'b0;
                if (kj_done)                         d.st = S_WR_HS;
                else if (tmr == TW'(HOST_TO - 1))    d.st = S_WR_FS;
            end
            S_WR_HS: begin
                reg_req  = 1'b1;
                reg_data = fctrl(2'b00, 1'b0, 2'b00);
                if (reg_ack) begin
                    d.st = S_HS;
                    d.hs = 1'b1;
                end
            end
            S_WR_FS: begin
                reg_req  = 1'b1;
                reg_data = fctrl(2'b01, 1'b1, 2'b00);
                if (reg_ack) begin
                    d.st = S_IDLE;
                    d.hs = 1'b0;
                end
            end
            S_HS: begin
                d.st = S_HS;
            end
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st <= S_IDLE;
            q.hs <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign hs_mode = q.hs;

    // Independent count of chirp data cycles, used only by the checks below
    logic [TW-1:0] chk_chirp_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                     chk_chirp_q <= '0;
        else if (tx_stp)                                chk_chirp_q <= '0;
        else if (tx_valid && tx_data == 8'h00 && chk_chirp_q != '1)
                                                        chk_chirp_q <= chk_chirp_q + TW'(1);
    end

    // R2: request and its payload hold until acknowledged
    p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_req && !reg_ack) |=> (reg_req && $stable(reg_data) && $stable(reg_addr)));

    // R4: stop lasts one cycle
    p_stp_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_stp |=> !tx_stp);

    // R4: the chirp carried exactly the configured number of data cycles
    p_chirp_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_stp |-> chk_chirp_q == TW'(CHIRP_CYC));

    // R6: high-speed mode only follows an acknowledged high-speed write
    p_hs_after_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_mode) |-> ($past(reg_ack) && $past(reg_req) && $past(reg_data) == FC_HS));

    // R9: register and transmit paths are never driven together
    p_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_req && tx_valid));

endmodule

// File: tb/sim_hs_chirp_seq.sv
module sim_hs_chirp_seq;
    localparam int SE0_CYC   = 8;
    localparam int CHIRP_CYC = 20;
    localparam int HOST_TO   = 60;
    localparam int PAIRS     = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] line_state = 2'b01;
    logic       diff_valid = 1'b0;
    logic       reg_req, tx_valid, tx_stp, hs_mode;
    logic [5:0] reg_addr;
    logic [7:0] reg_data, tx_data;
    logic       reg_ack = 1'b0;
    logic       tx_nxt = 1'b0;

    int tests = 0;
    int fails = 0;
    bit ended = 1'b0;

    always #10 clk = ~clk;

    hs_chirp_seq #(.SE0_CYC(SE0_CYC), .CHIRP_CYC(CHIRP_CYC),
                   .HOST_TO(HOST_TO), .PAIRS(PAIRS)) u0 (
        .clk(clk), .rst_n(rst_n), .line_state(line_state), .diff_valid(diff_valid),
        .reg_req(reg_req), .reg_addr(reg_addr), .reg_data(reg_data), .reg_ack(reg_ack),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_nxt(tx_nxt), .tx_stp(tx_stp),
        .hs_mode(hs_mode)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; line_state = 2'b01; diff_valid = 1'b0; reg_ack = 1'b0; tx_nxt = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // Register engine model: wait for a request, check it, acknowledge once
    task automatic serve_reg(input logic [7:0] exp, input int bound, input string tag);
        for (int i = 0; i < bound && !reg_req; i++) @(negedge clk);
        chk(reg_req, tag, reg_req, 1);
        chk(reg_addr == 6'h04, tag, reg_addr, 6'h04);
        chk(reg_data == exp, tag, reg_data, exp);
        @(negedge clk);
        chk(reg_req && reg_data == exp, "R2 hold", reg_data, exp);
        reg_ack = 1'b1;
        @(negedge clk);
        reg_ack = 1'b0;
        chk(!reg_req, "R2 release", reg_req, 0);
    endtask

    // Reset, hold SE0, run the chirp; returns at the stop cycle
    task automatic run_to_listen(input bit deep);
        int n;
        bit clash;
        do_reset();
        line_state = 2'b00;
        serve_reg(8'h14, SE0_CYC + 5, "R1 chirp write");
        chk(tx_valid && tx_data == 8'h40, "R3 command", tx_data, 8'h40);
        if (deep) begin
            repeat (3) @(negedge clk);
            chk(tx_valid && tx_data == 8'h40, "R3 waits for nxt", tx_data, 8'h40);
        end
        tx_nxt = 1'b1;
        @(negedge clk);
        tx_nxt = 1'b0;
        n = 0;
        clash = 1'b0;
        for (int i = 0; i < 1000 && !tx_stp; i++) begin
            if (tx_valid && tx_data == 8'h00) n++;
            if (tx_valid && reg_req) clash = 1'b1;
            @(negedge clk);
        end
        if (deep) begin
            chk(n == CHIRP_CYC, "R4 chirp length", n, CHIRP_CYC);
            chk(!clash, "R9 exclusive", clash, 0);
        end
        chk(tx_stp, "R4 stop", tx_stp, 1);
    endtask

    task automatic drive(input logic [1:0] sym, input logic dv);
        line_state = sym;
        diff_valid = dv;
        @(negedge clk);
    endtask

    task automatic t_reset();
        do_reset();
        chk(!reg_req && !tx_valid && !tx_stp && !hs_mode, "R8 reset state",
            {reg_req, tx_valid, tx_stp, hs_mode}, 0);
    endtask

    task automatic t_short_se0();
        bit seen;
        do_reset();
        line_state = 2'b00;
        repeat (SE0_CYC - 1) @(negedge clk);
        line_state = 2'b01;
        seen = 1'b0;
        for (int i = 0; i < 20; i++) begin
            if (reg_req || tx_valid) seen = 1'b1;
            @(negedge clk);
        end
        chk(!seen, "R1 short SE0 ignored", seen, 0);
    endtask

    task automatic t_hs_pairs();
        run_to_listen(1'b1);
        @(negedge clk);
        chk(!tx_stp, "R4 stop one cycle", tx_stp, 0);
        for (int i = 0; i < PAIRS; i++) begin
            drive(2'b10, 1'b1);
            drive(2'b01, 1'b1);
        end
        serve_reg(8'h00, 5, "R6 hs write");
        chk(hs_mode, "R6 hs_mode", hs_mode, 1);
        line_state = 2'b00;
        repeat (SE0_CYC + 10) @(negedge clk);
        chk(hs_mode && !reg_req && !tx_valid, "R6 hs_mode stays", hs_mode, 1);
    endtask

    task automatic t_repeat_k();
        run_to_listen(1'b0);
        @(negedge clk);
        drive(2'b01, 1'b1);
        drive(2'b10, 1'b1); drive(2'b10, 1'b1);
        drive(2'b01, 1'b1); drive(2'b01, 1'b1);
        drive(2'b10, 1'b1); drive(2'b01, 1'b1);
        drive(2'b10, 1'b1); drive(2'b01, 1'b1);
        line_state = 2'b01;
        serve_reg(8'h00, 5, "R5 repeated K counted once");
        chk(hs_mode, "R5 hs after repeats", hs_mode, 1);
    endtask

    task automatic t_timeout(input bit gate_off);
        int k;
        run_to_listen(1'b0);
        k = 0;
        for (int i = 0; i < HOST_TO + 10 && !reg_req; i++) begin
            @(negedge clk);
            k++;
            if (gate_off) begin
                line_state = (i % 2 == 0) ? 2'b10 : 2'b01;
                diff_valid = 1'b0;
            end else if (i < 2 * (PAIRS - 1)) begin
                line_state = (i % 2 == 0) ? 2'b10 : 2'b01;
                diff_valid = 1'b1;
            end else begin
                line_state = 2'b01;
            end
        end
        if (gate_off) chk(k == HOST_TO + 1, "R5 diff_valid gates pairs", k, HOST_TO + 1);
        else          chk(k == HOST_TO + 1, "R7 timeout cycle", k, HOST_TO + 1);
        serve_reg(8'h05, 2, "R7 fs write");
        chk(!hs_mode && !tx_valid, "R7 back to full speed", hs_mode, 0);
        line_state = 2'b00;
        serve_reg(8'h14, SE0_CYC + 5, "R7 restart after SE0");
    endtask

    initial begin
        t_reset();
        t_short_se0();
        t_hs_pairs();
        t_repeat_k();
        t_timeout(1'b0);
        t_timeout(1'b1);
        if (!ended) begin
            ended = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!ended) begin
            ended = 1'b1;
            tests++;
            fails++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule